// File: doc/BRIEF.md
# I2C Serial Clock Period Generator

This block produces the serial clock waveform of an I2C master. A bit engine sets a run request, and the block drives the clock line through an open-drain pull-down. The low and high phases take their lengths from programmable cycle counts. There are two count pairs, one for standard speed and one for fast speed, and a two-bit speed field picks between them. A count that is programmed too small is raised to a fixed floor before it is used.

Once a run starts, the line stays released for a hold interval before the first pull-low. After that the block alternates low and high phases for as long as the run request stays high. The low phase is counted from the first cycle of the pull-down, so the bus fall time falls inside it. The high phase carries a fixed overhead on top of its count. It only counts cycles in which the sampled line is actually high, so a slave can stretch the clock by holding the line low.

Three one-cycle strobes go to the bit engine: one at the falling edge, one at the rising edge and one in the middle of the high phase. Dropping the enable releases the line and stops the block within one clock.

Top module: `scl_gen`

## Requirements
- R1: While reset is held, and on the first cycle after it, the line is released (scl_drive_low = 0) and all three strobes are 0.
- R2: A run request seen while the block is idle and enabled keeps the line released for exactly HCNT+3 clocks. The first pull-low follows immediately.
- R3: Each low phase lasts exactly LCNT+1 clocks, counted from the first cycle in which scl_drive_low is 1. scl_fall is 1 in that first cycle only.
- R4: When nothing holds the line low, each high phase lasts exactly HCNT+8 clocks.
- R5: The high-phase count advances only in cycles where scl_in is 1. Each cycle in which another device holds the line low lengthens the high phase, and the block never pulls low during such a cycle.
- R6: speed_sel = 2 selects the fast pair (fast_hi, fast_lo). Every other value (0, 1, 3) selects the standard pair (std_hi, std_lo).
- R7: A high count below 6 is used as 6, and a low count below 8 is used as 8. Every low phase therefore lasts at least 9 clocks.
- R8: When en is 0, the line is released and all strobes are 0 in the following cycle, and the block returns to idle. The next run starts again with the full R2 hold.
- R9: At the end of a high phase, the next low phase begins at once if the run request is 1. If it is 0, the block goes idle and leaves the line released.
- R10: scl_rise is 1 in the cycle after the first counted high cycle. scl_mid is 1 exactly floor((HCNT+8)/2) cycles after scl_rise, when there is no stretching.
- R11: The active count pair is captured when a run starts and at each high-to-low boundary. A count written during a period takes effect from the next period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Block enable; 0 releases the line and idles |
| run | input | 1 | Run request from the bit engine |
| scl_in | input | 1 | Sampled clock line level |
| speed_sel | input | 2 | 2 = fast pair, other = standard pair |
| std_hi | input | 16 | Standard high count |
| std_lo | input | 16 | Standard low count |
| fast_hi | input | 16 | Fast high count |
| fast_lo | input | 16 | Fast low count |
| scl_drive_low | output | 1 | 1 = pull the line low, 0 = release |
| scl_rise | output | 1 | Rising-edge strobe |
| scl_fall | output | 1 | Falling-edge strobe |
| scl_mid | output | 1 | Mid-high strobe |

## Verification
Two things can land in the same cycle: a slave releasing a stretched line, and the first counted cycle of the high phase. The bench holds the modelled line low for a random number of high-phase cycles and releases it at a sample point. It then expects the high length, the scl_rise position and the scl_mid position all to shift by exactly the stretch.

A second coincidence is the period boundary. There the count reload meets the run decision, while a new low count has already been written mid-period. The bench drops the run request during the second low phase. It then checks that the old count still governs the first low, that the new count governs the second low, and that no further pull-low follows.

// File: rtl/scl_gen_pkg.sv
`timescale 1ns/1ps
package scl_gen_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_HOLD = 2'd1,
    PH_LOW  = 2'd2,
    PH_HIGH = 2'd3
  } scl_phase_e;

  localparam logic [1:0] SPD_FAST = 2'd2;
endpackage

// File: rtl/scl_timing_sel.sv
`timescale 1ns/1ps
module scl_timing_sel
  import scl_gen_pkg::*;
#(
  parameter int CW     = 16,
  parameter int MIN_HI = 6,
  parameter int MIN_LO = 8
) (
  input  logic [1:0]    speed_sel,
  input  logic [CW-1:0] std_hi,
  input  logic [CW-1:0] std_lo,
  input  logic [CW-1:0] fast_hi,
  input  logic [CW-1:0] fast_lo,
  output logic [CW-1:0] hi_eff,
  output logic [CW-1:0] lo_eff
);
  localparam logic [CW-1:0] HI_FLOOR = CW'(MIN_HI);
  localparam logic [CW-1:0] LO_FLOOR = CW'(MIN_LO);

  logic          use_fast;
  logic [CW-1:0] hi_raw;
  logic [CW-1:0] lo_raw;

  always_comb begin
    use_fast = (speed_sel == SPD_FAST);
    hi_raw   = use_fast ? fast_hi : std_hi;
    lo_raw   = use_fast ? fast_lo : std_lo;
    hi_eff   = (hi_raw < HI_FLOOR) ? HI_FLOOR : hi_raw;
    lo_eff   = (lo_raw < LO_FLOOR) ? LO_FLOOR : lo_raw;
  end
endmodule

// File: rtl/scl_phase_ctrl.sv
`timescale 1ns/1ps
module scl_phase_ctrl
  import scl_gen_pkg::*;
#(
  parameter int CW         = 16,
  parameter int HOLD_EXTRA = 3,
  parameter int LOW_EXTRA  = 1,
  parameter int HIGH_EXTRA = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic          run,
  input  logic          scl_in,
  input  logic [CW-1:0] hi_sel,
  input  logic [CW-1:0] lo_sel,
  output scl_phase_e    phase,
  output scl_phase_e    nxt_phase,
  output logic [CW:0]   cnt,
  output logic [CW-1:0] hi_q
);
  localparam int TW = CW + 1;
  localparam logic [TW-1:0] HOLD_ADD = TW'(HOLD_EXTRA - 1);
  localparam logic [TW-1:0] LOW_ADD  = TW'(LOW_EXTRA - 1);
  localparam logic [TW-1:0] HIGH_ADD = TW'(HIGH_EXTRA - 1);

  logic [CW-1:0] lo_q;
  logic [TW-1:0] cnt_n;
  logic [TW-1:0] hold_end;
  logic [TW-1:0] low_end;
  logic [TW-1:0] high_end;
  logic          load;

  assign hold_end = {1'b0, hi_q} + HOLD_ADD;
  assign low_end  = {1'b0, lo_q} + LOW_ADD;
  assign high_end = {1'b0, hi_q} + HIGH_ADD;

  always_comb begin
    nxt_phase = phase;
    cnt_n     = cnt;
    load      = 1'b0;
    if (!en) begin
      nxt_phase = PH_IDLE;
      cnt_n     = '0;
    end else begin
      unique case (phase)
        PH_IDLE: begin
          if (run) begin
            nxt_phase = PH_HOLD;
            cnt_n     = '0;
            load      = 1'b1;
          end
        end
        PH_HOLD: begin
          if (cnt == hold_end) begin
            nxt_phase = PH_LOW;
            cnt_n     = '0;
          end else begin
            cnt_n = cnt + 1'b1;
          end
        end
        PH_LOW: begin
          if (cnt == low_end) begin
            nxt_phase = PH_HIGH;
            cnt_n     = '0;
          end else begin
            cnt_n = cnt + 1'b1;
          end
        end
        PH_HIGH: begin
          if (scl_in) begin
            if (cnt == high_end) begin
              cnt_n = '0;
              if (run) begin
                nxt_phase = PH_LOW;
                load      = 1'b1;
              end else begin
                nxt_phase = PH_IDLE;
              end
            end else begin
              cnt_n = cnt + 1'b1;
            end
          end
        end
        default: nxt_phase = PH_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase <= PH_IDLE;
      cnt   <= '0;
      hi_q  <= '0;
      lo_q  <= '0;
    end else begin
      phase <= nxt_phase;
      cnt   <= cnt_n;
      if (load) begin
        hi_q <= hi_sel;
        lo_q <= lo_sel;
      end
    end
  end
endmodule

// File: rtl/scl_strobe_reg.sv
`timescale 1ns/1ps
module scl_strobe_reg
  import scl_gen_pkg::*;
#(
  parameter int CW         = 16,
  parameter int HIGH_EXTRA = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic          scl_in,
  input  scl_phase_e    phase,
  input  scl_phase_e    nxt_phase,
  input  logic [CW:0]   cnt,
  input  logic [CW-1:0] hi_q,
  output logic          drive_low,
  output logic          rise,
  output logic          fall,
  output logic          mid
);
  localparam int TW = CW + 1;

  logic [TW-1:0] mid_pt;
  logic          counting;

  assign mid_pt   = ({1'b0, hi_q} + TW'(HIGH_EXTRA)) >> 1;
  assign counting = en && (phase == PH_HIGH) && scl_in;

  always_ff @(posedge clk) begin
    if (rst) begin
      drive_low <= 1'b0;
      rise      <= 1'b0;
      fall      <= 1'b0;
      mid       <= 1'b0;
    end else begin
      drive_low <= (nxt_phase == PH_LOW);
      fall      <= (nxt_phase == PH_LOW) && (phase != PH_LOW);
      rise      <= counting && (cnt == '0);
      mid       <= counting && (cnt == mid_pt);
    end
  end
endmodule

// File: rtl/scl_gen.sv
`timescale 1ns/1ps
module scl_gen
  import scl_gen_pkg::*;
#(
  parameter int CW         = 16,
  parameter int MIN_HI     = 6,
  parameter int MIN_LO     = 8,
  parameter int HOLD_EXTRA = 3,
  parameter int LOW_EXTRA  = 1,
  parameter int HIGH_EXTRA = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic          run,
  input  logic          scl_in,
  input  logic [1:0]    speed_sel,
  input  logic [CW-1:0] std_hi,
  input  logic [CW-1:0] std_lo,
  input  logic [CW-1:0] fast_hi,
  input  logic [CW-1:0] fast_lo,
  output logic          scl_drive_low,
  output logic          scl_rise,
  output logic          scl_fall,
  output logic          scl_mid
);
  logic [CW-1:0] hi_eff;
  logic [CW-1:0] lo_eff;
  logic [CW-1:0] hi_q;
  logic [CW:0]   cnt;
  scl_phase_e    cur_phase;
  scl_phase_e    nxt_phase;

  scl_timing_sel #(
    .CW(CW), .MIN_HI(MIN_HI), .MIN_LO(MIN_LO)
  ) u_sel (
    .speed_sel(speed_sel),
    .std_hi(std_hi),
    .std_lo(std_lo),
    .fast_hi(fast_hi),
    .fast_lo(fast_lo),
    .hi_eff(hi_eff),
    .lo_eff(lo_eff)
  );

  scl_phase_ctrl #(
    .CW(CW), .HOLD_EXTRA(HOLD_EXTRA), .LOW_EXTRA(LOW_EXTRA), .HIGH_EXTRA(HIGH_EXTRA)
  ) u_ctrl (
    .clk(clk),
    .rst(rst),
    .en(en),
    .run(run),
    .scl_in(scl_in),
    .hi_sel(hi_eff),
    .lo_sel(lo_eff),
    .phase(cur_phase),
    .nxt_phase(nxt_phase),
    .cnt(cnt),
    .hi_q(hi_q)
  );

  scl_strobe_reg #(
    .CW(CW), .HIGH_EXTRA(HIGH_EXTRA)
  ) u_strb (
    .clk(clk),
    .rst(rst),
    .en(en),
    .scl_in(scl_in),
    .phase(cur_phase),
    .nxt_phase(nxt_phase),
    .cnt(cnt),
    .hi_q(hi_q),
    .drive_low(scl_drive_low),
    .rise(scl_rise),
    .fall(scl_fall),
    .mid(scl_mid)
  );
endmodule

// File: rtl/scl_gen_chk.sv
`timescale 1ns/1ps
module scl_gen_chk
  import scl_gen_pkg::*;
#(
  parameter int MIN_LO = 8
) (
  input logic       clk,
  input logic       rst,
  input logic       en,
  input logic       scl_in,
  input logic       scl_drive_low,
  input logic       scl_rise,
  input logic       scl_fall,
  input logic       scl_mid,
  input scl_phase_e phase
);
  logic [31:0] low_run;

  always_ff @(posedge clk) begin
    if (rst)                low_run <= '0;
    else if (scl_drive_low) low_run <= low_run + 1'b1;
    else                    low_run <= '0;
  end

  // R3
  fall_on_first_low_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(scl_drive_low) |-> scl_fall);

  // R5
  stretch_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (en && phase == PH_HIGH && !scl_in) |=> !scl_drive_low);

  // R7
  low_floor_chk: assert property (@(posedge clk) disable iff (rst)
    ($fell(scl_drive_low) && en && $past(en)) |-> (low_run >= 32'(MIN_LO + 1)));

  // R8
  disable_release_chk: assert property (@(posedge clk) disable iff (rst)
    !en |=> (!scl_drive_low && !scl_rise && !scl_fall && !scl_mid));

  // R10
  high_strobe_chk: assert property (@(posedge clk) disable iff (rst)
    (scl_rise || scl_mid) |-> !scl_drive_low);
endmodule

bind scl_gen scl_gen_chk #(.MIN_LO(MIN_LO)) u_chk (
  .clk(clk),
  .rst(rst),
  .en(en),
  .scl_in(scl_in),
  .scl_drive_low(scl_drive_low),
  .scl_rise(scl_rise),
  .scl_fall(scl_fall),
  .scl_mid(scl_mid),
  .phase(cur_phase)
);

// File: tb/scl_gen_tb.sv
`timescale 1ns/1ps
module scl_gen_tb;
  localparam int CW = 16;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          en = 1'b0;
  logic          run = 1'b0;
  logic          stretch = 1'b0;
  logic [1:0]    speed_sel = 2'd1;
  logic [CW-1:0] std_hi = '0, std_lo = '0, fast_hi = '0, fast_lo = '0;
  logic          scl_drive_low, scl_rise, scl_fall, scl_mid;
  logic          scl_in;
  int            checks = 0;
  int            errors = 0;
  bit            finished = 1'b0;

  always #10 clk = ~clk;

  assign scl_in = !(scl_drive_low || stretch);

  scl_gen u_dut (
    .clk(clk), .rst(rst), .en(en), .run(run), .scl_in(scl_in),
    .speed_sel(speed_sel), .std_hi(std_hi), .std_lo(std_lo),
    .fast_hi(fast_hi), .fast_lo(fast_lo),
    .scl_drive_low(scl_drive_low), .scl_rise(scl_rise),
    .scl_fall(scl_fall), .scl_mid(scl_mid)
  );

  function automatic int eff(input int v, input int mn);
    return (v < mn) ? mn : v;
  endfunction

  task automatic chk_eq(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic run_case(input logic [1:0] spd, input int hi, input int lo,
                          input int lo2, input int s);
    int eh, el, el2, n, idx, rise_at, mid_at, f, lows, lim;
    eh = eff(hi, 6); el = eff(lo, 8); el2 = eff(lo2, 8);
    @(negedge clk);
    speed_sel = spd;
    if (spd == 2'd2) begin
      fast_hi = 16'(hi); fast_lo = 16'(lo); std_hi = 16'(hi + 13); std_lo = 16'(lo + 17);
    end else begin
      std_hi = 16'(hi); std_lo = 16'(lo); fast_hi = 16'(hi + 11); fast_lo = 16'(lo + 19);
    end
    run = 1'b1;
    n = 0; lim = 0;
    forever begin
      @(negedge clk);
      if (scl_drive_low || lim > 5000) break;
      n++; lim++;
    end
    chk_eq("R2 R6 R7 hold length", n, eh + 3);
    chk_eq("R3 fall strobe at first low", int'(scl_fall), 1);
    stretch = (s > 0);
    if (spd == 2'd2) fast_lo = 16'(lo2); else std_lo = 16'(lo2);
    n = 1; lim = 0;
    forever begin
      @(negedge clk);
      if (!scl_drive_low || lim > 5000) break;
      n++; lim++;
    end
    chk_eq("R3 R11 first low length", n, el + 1);
    idx = 1; rise_at = 0; mid_at = 0; lim = 0;
    forever begin
      if (scl_rise) rise_at = idx;
      if (scl_mid)  mid_at = idx;
      if (s > 0 && idx == s) stretch = 1'b0;
      @(negedge clk);
      if (scl_drive_low || lim > 5000) break;
      idx++; lim++;
    end
    f = (s == 0) ? 1 : s;
    chk_eq("R4 R5 high length", idx, f - 1 + eh + 8);
    chk_eq("R10 rise strobe position", rise_at, f + 1);
    chk_eq("R10 mid strobe position", mid_at, f + (eh + 8) / 2 + 1);
    run = 1'b0;
    n = 1; lim = 0;
    forever begin
      @(negedge clk);
      if (!scl_drive_low || lim > 5000) break;
      n++; lim++;
    end
    chk_eq("R11 second low uses new count", n, el2 + 1);
    lows = 0;
    for (int k = 0; k < eh + 40; k++) begin
      @(negedge clk);
      if (scl_drive_low) lows++;
    end
    chk_eq("R9 idle after run dropped", lows, 0);
  endtask

  task automatic en_drop_case();
    int n, bad;
    @(negedge clk);
    speed_sel = 2'd1; std_hi = 16'd10; std_lo = 16'd12;
    run = 1'b1;
    n = 0;
    while (!scl_drive_low && n < 5000) begin @(negedge clk); n++; end
    repeat (3) @(negedge clk);
    en = 1'b0;
    @(negedge clk);
    chk_eq("R8 released after disable", int'(scl_drive_low), 0);
    chk_eq("R8 strobes zero after disable", int'(scl_rise | scl_fall | scl_mid), 0);
    bad = 0;
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      if (scl_drive_low) bad++;
    end
    chk_eq("R8 stays released while disabled", bad, 0);
    en = 1'b1;
    n = 0;
    forever begin
      @(negedge clk);
      if (scl_drive_low || n > 5000) break;
      n++;
    end
    chk_eq("R8 R2 fresh hold after re-enable", n, 13);
    run = 1'b0;
    repeat (80) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog expired actual %0d expected %0d", 1, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4021));
    repeat (4) @(negedge clk);
    chk_eq("R1 released in reset", int'(scl_drive_low), 0);
    rst = 1'b0;
    @(negedge clk);
    chk_eq("R1 released after reset", int'(scl_drive_low), 0);
    chk_eq("R1 strobes zero after reset", int'(scl_rise | scl_fall | scl_mid), 0);
    en = 1'b1;
    repeat (3) @(negedge clk);
    chk_eq("R1 idle without run", int'(scl_drive_low), 0);

    run_case(2'd1, 20, 25, 12, 0);
    run_case(2'd2, 9, 10, 30, 0);
    run_case(2'd0, 12, 14, 9, 3);
    run_case(2'd3, 7, 9, 11, 1);
    run_case(2'd1, 5, 7, 3, 0);
    run_case(2'd2, 6, 8, 0, 2);
    run_case(2'd1, 0, 0, 8, 4);
    en_drop_case();

    for (int i = 0; i < 10; i++) begin
      logic [1:0] sp;
      sp = 2'($urandom_range(0, 3));
      run_case(sp, int'($urandom_range(0, 30)), int'($urandom_range(0, 30)),
               int'($urandom_range(0, 30)), int'($urandom_range(0, 6)));
    end

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule